// File: doc/BRIEF.md
# Two-Way Processor Mailbox

This block passes single messages between two processors, called side A and side B. Each side has its own register port. Both ports reach the same eight-word map, which holds two directions: A-to-B (sent by A) and B-to-A (sent by B). Each direction has a command word, a data word, an enable word and a status word. The sender writes its message. A write of the selected kind raises a pending flag, and that flag can interrupt the receiver. The receiver reads the command and data words and then clears the pending flag. That clear raises a consumed flag in the status word of the opposite direction, so the original sender learns of completion by interrupt and does not have to poll.

The register ports have no back-pressure. The block accepts a write in every cycle in which `*_sel` and `*_we` are high. Read data is combinational from `*_addr` and needs no select. Interrupt outputs are plain level signals.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, every command, data, enable and status word reads zero, both interrupts are low, and the trigger selection is "command write".
- R2: The address is 3 bits. Bit 2 selects the direction (0 = A-to-B, 1 = B-to-A). Bits [1:0] select the word: 0 command, 1 data, 2 enable, 3 status. Enable bit 8 picks the write that raises the pending flag (status bit 0): 0 means a command write, 1 means a data write. The flag is set at the clock edge of that write.
- R3: While a direction's pending flag is set, writes to its command or data word leave both words unchanged. Each such write sets the sticky overflow flag at status bit 2.
- R4: Status bits are write-one-to-clear, bit by bit. Writing 1 to bit 0, 1 or 2 clears only that flag, and writing 0 has no effect. Either port may clear.
- R5: When a set pending flag is cleared, the consumed flag (status bit 1) of the opposite direction is set at the same edge.
- R6: If a consumed flag is set and cleared in the same cycle, it ends up set.
- R7: Enable writes are masked. Value bits 0, 1 and 8 change only where bits 16, 17 and 24 of the written word are 1. Writing only a mask bit clears that enable.
- R8: Side B's interrupt is the OR of A-to-B status bits [1:0] ANDed with enable bits [1:0]. Side A's interrupt is the same for B-to-A. Each is registered and follows the status change by one cycle, and it stays low while neither status bit is set.
- R9: Only the sending side can write a direction's command and data words. A write by the other side has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| a_sel | input | 1 | Side A access strobe |
| a_we | input | 1 | Side A write when high |
| a_addr | input | 3 | Side A word address |
| a_wdata | input | DATA_W | Side A write data |
| a_rdata | output | DATA_W | Side A read data |
| a_irq | output | 1 | Interrupt toward side A (B-to-A events) |
| b_sel | input | 1 | Side B access strobe |
| b_we | input | 1 | Side B write when high |
| b_addr | input | 3 | Side B word address |
| b_wdata | input | DATA_W | Side B write data |
| b_rdata | output | DATA_W | Side B read data |
| b_irq | output | 1 | Interrupt toward side B (A-to-B events) |

## Verification
Messages are sent under both trigger settings. With the command setting, a data write alone must leave the pending flag low. With the data setting, a command write alone must leave it low. These two runs show the selection working in both directions. Writes into a busy channel, writes from the wrong side, enable writes with and without their mask bits, and a consumed flag set and cleared in one cycle each isolate a single rule. The interrupt lines are compared every cycle against a model that updates one cycle late, which separates a registered interrupt from a combinational one.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    REG_CMD = 2'd0,
    REG_DAT = 2'd1,
    REG_EN  = 2'd2,
    REG_ST  = 2'd3
  } mbox_reg_e;

  // status bit positions
  localparam int ST_PEND = 0;
  localparam int ST_CONS = 1;
  localparam int ST_OVF  = 2;

  function automatic logic wr_hit(input logic sel, input logic we,
                                  input logic [ADDR_W-1:0] addr,
                                  input logic dir, input mbox_reg_e rg);
    return sel & we & (addr == {dir, rg});
  endfunction
endpackage

// File: rtl/mbox_dir.sv
// One message direction: stored words, enables, trigger choice and flags.
module mbox_dir #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] msg_wdata,
  input  logic              en_we,
  input  logic [2:0]        en_val,     // {trigger, enable1, enable0}
  input  logic [2:0]        en_msk,
  input  logic [2:0]        st_clr,     // write-one-to-clear bits
  input  logic              cons_set,   // peer consumed our opposite message
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] dat_q,
  output logic [1:0]        en_q,
  output logic              trig_q,
  output logic              pend_q,
  output logic              cons_q,
  output logic              ovf_q,
  output logic              consumed_evt
);
  logic accept;
  logic raise;

  assign accept       = ~pend_q;
  assign raise        = accept & (trig_q ? dat_we : cmd_we);
  assign consumed_evt = pend_q & st_clr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      dat_q  <= '0;
      en_q   <= '0;
      trig_q <= 1'b0;
      pend_q <= 1'b0;
      cons_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (cmd_we && accept) cmd_q <= msg_wdata;
      if (dat_we && accept) dat_q <= msg_wdata;
      pend_q <= raise | (pend_q & ~st_clr[0]);
      cons_q <= cons_set | (cons_q & ~st_clr[1]);
      ovf_q  <= (pend_q & (cmd_we | dat_we)) | (ovf_q & ~st_clr[2]);
      if (en_we) begin
        for (int i = 0; i < 2; i++) begin
          if (en_msk[i]) en_q[i] <= en_val[i];
        end
        if (en_msk[2]) trig_q <= en_val[2];
      end
    end
  end
endmodule

// File: rtl/mbox_irq.sv
// Registered interrupt for one receiving side.
module mbox_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] st,
  input  logic [1:0] en,
  output logic       irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(st & en);
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbox_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TRIG_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_sel,
  input  logic              a_we,
  input  logic [2:0]        a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_irq,
  input  logic              b_sel,
  input  logic              b_we,
  input  logic [2:0]        b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_irq
);
  localparam int NDIR    = 2;
  localparam int MASK_SH = DATA_W / 2;

  logic [NDIR-1:0]   p_sel, p_we;
  logic [ADDR_W-1:0] p_addr  [NDIR];
  logic [DATA_W-1:0] p_wdata [NDIR];
  logic [DATA_W-1:0] p_rdata [NDIR];

  logic [DATA_W-1:0] cmd_q [NDIR];
  logic [DATA_W-1:0] dat_q [NDIR];
  logic [1:0]        en_q  [NDIR];
  logic [NDIR-1:0]   trig_q, pend_q, cons_q, ovf_q, cons_evt, irq_rx;

  assign p_sel      = {b_sel, a_sel};
  assign p_we       = {b_we, a_we};
  assign p_addr[0]  = a_addr;
  assign p_addr[1]  = b_addr;
  assign p_wdata[0] = a_wdata;
  assign p_wdata[1] = b_wdata;

  // direction d is sent by port d and received by the other port
  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    localparam logic DIR = (d == 1);
    localparam int   OTH = NDIR - 1 - d;

    logic            hit_cmd, hit_dat;
    logic [NDIR-1:0] hit_en, hit_st;
    logic [DATA_W-1:0] en_src;
    logic [2:0]      en_val, en_msk, clr;

    assign hit_cmd = wr_hit(p_sel[d], p_we[d], p_addr[d], DIR, REG_CMD);
    assign hit_dat = wr_hit(p_sel[d], p_we[d], p_addr[d], DIR, REG_DAT);

    for (genvar p = 0; p < NDIR; p++) begin : g_port
      assign hit_en[p] = wr_hit(p_sel[p], p_we[p], p_addr[p], DIR, REG_EN);
      assign hit_st[p] = wr_hit(p_sel[p], p_we[p], p_addr[p], DIR, REG_ST);
    end

    // side A wins an enable write collision
    assign en_src = hit_en[0] ? p_wdata[0] : p_wdata[1];
    assign en_val = {en_src[TRIG_BIT], en_src[1:0]};
    assign en_msk = {en_src[MASK_SH+TRIG_BIT], en_src[MASK_SH+1:MASK_SH]};
    assign clr    = ({3{hit_st[0]}} & p_wdata[0][2:0])
                  | ({3{hit_st[1]}} & p_wdata[1][2:0]);

    mbox_dir #(.DATA_W(DATA_W)) u_dir (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_we       (hit_cmd),
      .dat_we       (hit_dat),
      .msg_wdata    (p_wdata[d]),
      .en_we        (|hit_en),
      .en_val       (en_val),
      .en_msk       (en_msk),
      .st_clr       (clr),
      .cons_set     (cons_evt[OTH]),
      .cmd_q        (cmd_q[d]),
      .dat_q        (dat_q[d]),
      .en_q         (en_q[d]),
      .trig_q       (trig_q[d]),
      .pend_q       (pend_q[d]),
      .cons_q       (cons_q[d]),
      .ovf_q        (ovf_q[d]),
      .consumed_evt (cons_evt[d])
    );

    mbox_irq u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .st    ({cons_q[d], pend_q[d]}),
      .en    (en_q[d]),
      .irq   (irq_rx[d])
    );
  end

  assign a_irq = irq_rx[1];
  assign b_irq = irq_rx[0];

  always_comb begin
    for (int p = 0; p < NDIR; p++) begin
      logic      dsel;
      mbox_reg_e rg;
      dsel       = p_addr[p][ADDR_W-1];
      rg         = mbox_reg_e'(p_addr[p][1:0]);
      p_rdata[p] = '0;
      case (rg)
        REG_CMD: p_rdata[p] = cmd_q[dsel];
        REG_DAT: p_rdata[p] = dat_q[dsel];
        REG_EN: begin
          p_rdata[p][1:0]     = en_q[dsel];
          p_rdata[p][TRIG_BIT] = trig_q[dsel];
        end
        default: begin
          p_rdata[p][ST_PEND] = pend_q[dsel];
          p_rdata[p][ST_CONS] = cons_q[dsel];
          p_rdata[p][ST_OVF]  = ovf_q[dsel];
        end
      endcase
    end
  end

  assign a_rdata = p_rdata[0];
  assign b_rdata = p_rdata[1];
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_sel,
  input logic              a_we,
  input logic [2:0]        a_addr,
  input logic [DATA_W-1:0] a_wdata,
  input logic              b_sel,
  input logic              b_we,
  input logic [2:0]        b_addr,
  input logic [DATA_W-1:0] b_wdata,
  input logic              b_irq,
  input logic [1:0]        pend_q,
  input logic [1:0]        cons_q,
  input logic [1:0]        ovf_q,
  input logic [DATA_W-1:0] cmd0,
  input logic [1:0]        en0,
  input logic              trig0
);
  logic a_w0, b_w0, a_w2, b_w2;
  assign a_w0 = a_sel && a_we && (a_addr == 3'd0);
  assign b_w0 = b_sel && b_we && (b_addr == 3'd0);
  assign a_w2 = a_sel && a_we && (a_addr == 3'd2);
  assign b_w2 = b_sel && b_we && (b_addr == 3'd2);

  AST_PEND_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    a_w0 && !trig0 && !pend_q[0] |=> pend_q[0]); // R2
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[0] |=> $stable(cmd0)); // R3
  AST_BUSY_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[0] && a_w0 |=> ovf_q[0]); // R3
  AST_CONS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[0] && b_sel && b_we && (b_addr == 3'd3) && b_wdata[0] |=> cons_q[1]); // R5
  AST_QUIET_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q[0] && !cons_q[0] |=> !b_irq); // R8
  AST_EN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    a_w2 && !a_wdata[16] && !b_w2 |=> $stable(en0[0])); // R7
  AST_SENDER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    b_w0 && !a_w0 |=> $stable(cmd0)); // R9
endmodule

bind ipc_mailbox mbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_sel   (a_sel),
  .a_we    (a_we),
  .a_addr  (a_addr),
  .a_wdata (a_wdata),
  .b_sel   (b_sel),
  .b_we    (b_we),
  .b_addr  (b_addr),
  .b_wdata (b_wdata),
  .b_irq   (b_irq),
  .pend_q  (pend_q),
  .cons_q  (cons_q),
  .ovf_q   (ovf_q),
  .cmd0    (cmd_q[0]),
  .en0     (en_q[0]),
  .trig0   (trig_q[0])
);

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_sel = 0, a_we = 0, b_sel = 0, b_we = 0;
  logic [2:0]  a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  ipc_mailbox dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_sel(a_sel), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_sel(b_sel), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_cmd[2], m_dat[2];
  bit   [1:0]  m_en[2];
  bit          m_tr[2], m_pd[2], m_cs[2], m_ov[2];
  bit          m_irqa, m_irqb;
  bit          cw[2], dw[2], ev[2], ewr[2];
  logic [2:0]  clr[2];
  logic [31:0] ew[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < 2; d++) begin
        m_cmd[d] = 0; m_dat[d] = 0; m_en[d] = 0;
        m_tr[d] = 0; m_pd[d] = 0; m_cs[d] = 0; m_ov[d] = 0;
      end
      m_irqa = 0; m_irqb = 0;
    end else begin
      m_irqa = (m_pd[1] & m_en[1][0]) | (m_cs[1] & m_en[1][1]);
      m_irqb = (m_pd[0] & m_en[0][0]) | (m_cs[0] & m_en[0][1]);
      for (int d = 0; d < 2; d++) begin
        logic       s_sel, s_we;
        logic [2:0] s_ad;
        s_sel = d ? b_sel : a_sel;
        s_we  = d ? b_we : a_we;
        s_ad  = d ? b_addr : a_addr;
        cw[d] = s_sel && s_we && s_ad == 3'(d*4);
        dw[d] = s_sel && s_we && s_ad == 3'(d*4+1);
        clr[d] = 3'b000;
        if (a_sel && a_we && a_addr == 3'(d*4+3)) clr[d] = clr[d] | a_wdata[2:0];
        if (b_sel && b_we && b_addr == 3'(d*4+3)) clr[d] = clr[d] | b_wdata[2:0];
        ewr[d] = 1; ew[d] = 0;
        if (a_sel && a_we && a_addr == 3'(d*4+2)) ew[d] = a_wdata;
        else if (b_sel && b_we && b_addr == 3'(d*4+2)) ew[d] = b_wdata;
        else ewr[d] = 0;
        ev[d] = m_pd[d] & clr[d][0];
      end
      for (int d = 0; d < 2; d++) begin
        if (m_pd[d] && (cw[d] || dw[d])) m_ov[d] = 1;
        else if (clr[d][2]) m_ov[d] = 0;
        if (ev[1-d]) m_cs[d] = 1;
        else if (clr[d][1]) m_cs[d] = 0;
        if (!m_pd[d]) begin
          if (cw[d]) m_cmd[d] = (d ? b_wdata : a_wdata);
          if (dw[d]) m_dat[d] = (d ? b_wdata : a_wdata);
          if (m_tr[d] ? dw[d] : cw[d]) m_pd[d] = 1;
        end else if (clr[d][0]) m_pd[d] = 0;
        if (ewr[d]) begin
          if (ew[d][16]) m_en[d][0] = ew[d][0];
          if (ew[d][17]) m_en[d][1] = ew[d][1];
          if (ew[d][24]) m_tr[d]    = ew[d][8];
        end
      end
    end
  end

  function automatic logic [31:0] mread(input logic [2:0] ad);
    int d = ad[2];
    case (ad[1:0])
      2'd0: return m_cmd[d];
      2'd1: return m_dat[d];
      2'd2: return 32'(m_en[d]) | (32'(m_tr[d]) << 8);
      default: return {29'd0, m_ov[d], m_cs[d], m_pd[d]};
    endcase
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R8 a_irq vs model", 32'(a_irq), 32'(m_irqa));
      chk("R8 b_irq vs model", 32'(b_irq), 32'(m_irqb));
    end
  end

  task automatic cyc(input logic aw, input logic [2:0] aa, input logic [31:0] ad,
                     input logic bw, input logic [2:0] ba, input logic [31:0] bd);
    a_sel = aw; a_we = aw; a_addr = aa; a_wdata = ad;
    b_sel = bw; b_we = bw; b_addr = ba; b_wdata = bd;
    @(posedge clk);
    @(negedge clk);
    a_sel = 0; a_we = 0; a_addr = 0; a_wdata = 0;
    b_sel = 0; b_we = 0; b_addr = 0; b_wdata = 0;
  endtask

  task automatic rd(input int port, input logic [2:0] ad, input string tag,
                    output logic [31:0] v);
    if (port == 0) begin a_addr = ad; #1 v = a_rdata; a_addr = 0; end
    else begin b_addr = ad; #1 v = b_rdata; b_addr = 0; end
    chk({tag, " model"}, v, mread(ad));
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    started = 1;

    // R1 reset state
    for (int ad = 0; ad < 8; ad++) begin
      rd(0, 3'(ad), "R1 reset read", v);
      chk("R1 reset zero", v, 0);
    end
    chk("R1 irq low", {30'd0, a_irq, b_irq}, 0);

    // enables: B hears pending on A-to-B, A hears consumed on B-to-A
    cyc(0, 0, 0, 1, 3'd2, 32'h0001_0001);
    cyc(1, 3'd6, 32'h0002_0002, 0, 0, 0);

    // R2 command trigger: data write alone does not raise pending
    cyc(1, 3'd1, 32'h0000_1111, 0, 0, 0);
    rd(0, 3'd3, "R2 data no trigger", v); chk("R2 data no trigger", v, 0);
    cyc(1, 3'd0, 32'h0000_C0DE, 0, 0, 0);
    rd(1, 3'd3, "R2 cmd trigger", v); chk("R2 cmd trigger", v, 1);
    rd(1, 3'd0, "R2 cmd word", v); chk("R2 cmd word", v, 32'hC0DE);
    chk("R8 irq one cycle late", 32'(b_irq), 0);
    @(negedge clk);
    chk("R8 irq raised", 32'(b_irq), 1);

    // R3 busy writes ignored, overflow
    cyc(1, 3'd0, 32'h0000_0BAD, 0, 0, 0);
    cyc(1, 3'd1, 32'h0000_0BAD, 0, 0, 0);
    rd(0, 3'd0, "R3 cmd kept", v); chk("R3 cmd kept", v, 32'hC0DE);
    rd(0, 3'd1, "R3 dat kept", v); chk("R3 dat kept", v, 32'h1111);
    rd(0, 3'd3, "R3 ovf", v); chk("R3 ovf", v, 5);

    // R5 / R4 receiver clears pending
    cyc(0, 0, 0, 1, 3'd3, 32'h1);
    rd(0, 3'd3, "R4 only pend cleared", v); chk("R4 only pend cleared", v, 4);
    rd(0, 3'd7, "R5 consumed", v); chk("R5 consumed", v, 2);
    @(negedge clk);
    chk("R8 a_irq on consumed", 32'(a_irq), 1);
    cyc(1, 3'd3, 32'h4, 0, 0, 0);
    rd(0, 3'd3, "R4 ovf cleared", v); chk("R4 ovf cleared", v, 0);

    // R6 set and clear of consumed together
    cyc(1, 3'd0, 32'h22, 0, 0, 0);
    cyc(1, 3'd7, 32'h2, 1, 3'd3, 32'h1);
    rd(0, 3'd7, "R6 set wins", v); chk("R6 set wins", v, 2);
    cyc(1, 3'd7, 32'h2, 0, 0, 0);
    rd(0, 3'd7, "R4 consumed cleared", v); chk("R4 consumed cleared", v, 0);

    // R9 wrong side write
    cyc(0, 0, 0, 1, 3'd0, 32'h99);
    rd(0, 3'd0, "R9 cmd kept", v); chk("R9 cmd kept", v, 32'h22);
    rd(0, 3'd3, "R9 no pend", v); chk("R9 no pend", v, 0);

    // R7 masked enables
    cyc(0, 0, 0, 1, 3'd2, 32'h0000_0002);
    rd(1, 3'd2, "R7 no mask no change", v); chk("R7 no mask no change", v, 1);
    cyc(0, 0, 0, 1, 3'd2, 32'h0001_0000);
    rd(1, 3'd2, "R7 mask only clears", v); chk("R7 mask only clears", v, 0);

    // R8 quiet when no status set
    cyc(0, 0, 0, 1, 3'd2, 32'h0003_0003);
    repeat (2) @(negedge clk);
    chk("R8 quiet", 32'(b_irq), 0);

    // R2 data trigger
    cyc(1, 3'd2, 32'h0100_0100, 0, 0, 0);
    rd(0, 3'd2, "R2 trig read", v); chk("R2 trig read", v, 32'h103);
    cyc(1, 3'd0, 32'h77, 0, 0, 0);
    rd(0, 3'd3, "R2 cmd no trigger", v); chk("R2 cmd no trigger", v, 0);
    cyc(1, 3'd1, 32'h88, 0, 0, 0);
    rd(0, 3'd3, "R2 data trigger", v); chk("R2 data trigger", v, 1);
    rd(1, 3'd0, "R2 cmd stored", v); chk("R2 cmd stored", v, 32'h77);
    @(negedge clk);
    chk("R8 irq data trigger", 32'(b_irq), 1);

    // B-to-A direction with default trigger
    cyc(0, 0, 0, 1, 3'd4, 32'h5);
    rd(0, 3'd7, "R2 reverse pend", v); chk("R2 reverse pend", v, 1);
    rd(0, 3'd4, "R2 reverse cmd", v); chk("R2 reverse cmd", v, 5);

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule